// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-on to a programmed, idle state. It waits until the board reports a stable clock. It then holds the memory in a no-command window for a programmed number of cycles and raises the clock-enable pin part way through that window. After that it issues the fixed initialization commands: a precharge of all banks, a group of auto-refresh commands and a mode-register load. Each command is followed by its own minimum spacing, given in clock cycles. When the last spacing has elapsed, the block raises `init_done` and keeps the command pins at NOP, so that a later access or refresh engine can take over the pins.

A configuration input selects where the refresh group goes: before the mode-register load or after it. The mode value that is loaded comes from an input bus. Both the configuration input and the mode bus are captured once, when the sequence starts. All timing values are parameters in clock cycles. For example, a 100 µs power-up delay at 133 MHz is 13300 cycles. Every pin comes straight from a register. A synchronous reset restarts the whole sequence.

The command pins carry only the power-up flow, so there is no data stream and no back-pressure. All ports are plain level signals.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and after reset for as long as `clk_stable` has not been sampled high, the pins show CKE low, command INHIBIT ({cs_n,ras_n,cas_n,we_n}=1111), `ba` and `addr` zero, and `init_done` low.
- R2: Call the first rising edge that samples `clk_stable` high edge 0. After edges 0 to CKE_LOW_CYC, the pins show INHIBIT with CKE low. After edges CKE_LOW_CYC+1 to PWRUP_CYC, they show NOP (0111) with CKE high. Once CKE is high it stays high until reset.
- R3: After edge PWRUP_CYC+1, the pins show PRECHARGE ALL: {cs_n,ras_n,cas_n,we_n}=0010, `addr` bit AP_BIT set and every other address bit zero, and `ba`=0.
- R4: With `ref_late`=0, the command order is precharge, then NUM_REF AUTO REFRESH commands (0001), then LOAD MODE (0000).
- R5: With `ref_late`=1, the command order is precharge, then LOAD MODE, then NUM_REF AUTO REFRESH commands.
- R6: Each next command comes exactly TRP_CYC cycles after a precharge, TRFC_CYC cycles after a refresh and TMRD_CYC cycles after a mode load. Every cycle in between shows NOP with `addr` and `ba` zero.
- R7: The LOAD MODE command drives `ba`=0 and drives on `addr` the value that `mode_word` had at edge 0.
- R8: `init_done` rises exactly one spacing interval after the last command, the interval belonging to that command. It then stays high with CKE high and NOP on the pins until reset.
- R9: Changes to `ref_late`, `mode_word` or `clk_stable` after edge 0 have no effect on the sequence.
- R10: Asserting `rst` at any point returns the pins to the R1 state after the next edge. The sequence then starts again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High when the memory clock is stable; starts the sequence |
| ref_late | input | 1 | 1: refreshes after the mode load; 0: before it |
| mode_word | input | ADDR_W | Value to load into the mode register |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (always zero during init) |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High from the end of the last wait onward |

## Verification
The bench builds the block with a 20-cycle power-up window, CKE raised after 6 cycles, a precharge spacing of 2, a refresh spacing of 4, a mode-load spacing of 1 and two refreshes. With these values the whole sequence fits in about 40 cycles, so every pin on every cycle of every run can be compared with a schedule that the bench computes from the parameters. The one-cycle mode-load spacing makes a mode load sit directly against the next refresh with no NOP between them. Both refresh placements, several mode patterns, late changes to the inputs, and resets in both the CKE-low and command phases all fall inside this short run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_INH,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAITCLK,
    ST_PWRUP,
    ST_PRE,
    ST_REF,
    ST_LMR,
    ST_DONE
  } step_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC   = 13300,
  parameter int CKE_LOW_CYC = 6650,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 9,
  parameter int TMRD_CYC    = 2,
  parameter int NUM_REF     = 2,
  parameter int ADDR_W      = 13,
  parameter int CNT_W       = 14,
  parameter int REF_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_stable,
  input  logic              ref_late,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [CNT_W-1:0]  tmr_cnt,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output cmd_e              cmd,
  output logic              cke_want,
  output logic              done_want,
  output logic [ADDR_W-1:0] mode_q
);

  localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRP   = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRFC  = CNT_W'(TRFC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TMRD  = CNT_W'(TMRD_CYC - 1);
  localparam logic [CNT_W-1:0] CKE_AT   = CNT_W'(PWRUP_CYC - 1 - CKE_LOW_CYC);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REF - 1);

  step_e             step, step_n;
  logic              issue, issue_n;
  logic [REF_W-1:0]  ref_cnt, ref_n;
  logic              late_r, late_n;
  logic [ADDR_W-1:0] mode_r, mode_n;
  logic              cke_on;

  // Window count runs down; CKE comes up once CKE_LOW_CYC window cycles are gone
  assign cke_on = (tmr_cnt <= CKE_AT);

  always_comb begin
    step_n   = step;
    issue_n  = 1'b0;
    ref_n    = ref_cnt;
    late_n   = late_r;
    mode_n   = mode_r;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (step)
      ST_WAITCLK: if (clk_stable) begin
        step_n   = ST_PWRUP;
        tmr_load = 1'b1;
        tmr_val  = LD_PWRUP;
        late_n   = ref_late;
        mode_n   = mode_word;
      end
      ST_PWRUP: if (tmr_zero) begin
        step_n   = ST_PRE;
        issue_n  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LD_TRP;
      end
      ST_PRE: if (tmr_zero) begin
        issue_n  = 1'b1;
        tmr_load = 1'b1;
        if (late_r) begin
          step_n  = ST_LMR;
          tmr_val = LD_TMRD;
        end else begin
          step_n  = ST_REF;
          tmr_val = LD_TRFC;
        end
      end
      ST_REF: if (tmr_zero) begin
        ref_n = ref_cnt + 1'b1;
        if (ref_cnt != REF_LAST) begin
          issue_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_TRFC;
        end else if (late_r) begin
          step_n = ST_DONE;
        end else begin
          step_n   = ST_LMR;
          issue_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_TMRD;
        end
      end
      ST_LMR: if (tmr_zero) begin
        if (late_r) begin
          step_n   = ST_REF;
          issue_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_TRFC;
        end else begin
          step_n = ST_DONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_WAITCLK;
      issue   <= 1'b0;
      ref_cnt <= '0;
      late_r  <= 1'b0;
      mode_r  <= '0;
    end else begin
      step    <= step_n;
      issue   <= issue_n;
      ref_cnt <= ref_n;
      late_r  <= late_n;
      mode_r  <= mode_n;
    end
  end

  always_comb begin
    cke_want = 1'b1;
    cmd      = CMD_NOP;
    unique case (step)
      ST_WAITCLK: begin cke_want = 1'b0; cmd = CMD_INH; end
      ST_PWRUP:   begin cke_want = cke_on; cmd = cke_on ? CMD_NOP : CMD_INH; end
      ST_PRE:     cmd = issue ? CMD_PRE : CMD_NOP;
      ST_REF:     cmd = issue ? CMD_REF : CMD_NOP;
      ST_LMR:     cmd = issue ? CMD_LMR : CMD_NOP;
      default:    cmd = CMD_NOP;
    endcase
  end

  assign done_want = (step == ST_DONE);
  assign mode_q    = mode_r;

  AST_REF_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DONE) |-> (ref_cnt == REF_W'(NUM_REF))); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (step != ST_WAITCLK && $past(step) != ST_WAITCLK) |-> ($stable(late_r) && $stable(mode_r))); // R9

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic              cke_want,
  input  logic              done_want,
  input  logic [ADDR_W-1:0] mode_q,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  logic [3:0]        strobe_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    addr_n = '0;
    unique case (cmd)
      CMD_NOP: strobe_n = 4'b0111;
      CMD_PRE: begin strobe_n = 4'b0010; addr_n = ALL_BANKS; end
      CMD_REF: strobe_n = 4'b0001;
      CMD_LMR: begin strobe_n = 4'b0000; addr_n = mode_q; end
      default: strobe_n = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke                       <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba                        <= '0;
      addr                      <= '0;
      init_done                 <= 1'b0;
    end else begin
      cke                       <= cke_want;
      {cs_n, ras_n, cas_n, we_n} <= strobe_n;
      ba                        <= '0;
      addr                      <= addr_n;
      init_done                 <= done_want;
    end
  end

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R2

  AST_INH_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R8

  AST_DONE_NOP: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R8

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC   = 13300,
  parameter int CKE_LOW_CYC = 6650,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 9,
  parameter int TMRD_CYC    = 2,
  parameter int NUM_REF     = 2,
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_stable,
  input  logic              ref_late,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int CNT_W = $clog2(max4(PWRUP_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC) + 1);
  localparam int REF_W = $clog2(NUM_REF + 1);

  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val, tmr_cnt;
  cmd_e              cmd;
  logic              cke_want, done_want;
  logic [ADDR_W-1:0] mode_q;

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .expired  (tmr_zero)
  );

  sdram_init_fsm #(
    .PWRUP_CYC   (PWRUP_CYC),
    .CKE_LOW_CYC (CKE_LOW_CYC),
    .TRP_CYC     (TRP_CYC),
    .TRFC_CYC    (TRFC_CYC),
    .TMRD_CYC    (TMRD_CYC),
    .NUM_REF     (NUM_REF),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .REF_W       (REF_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .ref_late   (ref_late),
    .mode_word  (mode_word),
    .tmr_cnt    (tmr_cnt),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cmd        (cmd),
    .cke_want   (cke_want),
    .done_want  (done_want),
    .mode_q     (mode_q)
  );

  sdram_init_pins #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .AP_BIT (AP_BIT)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .cke_want  (cke_want),
    .done_want (done_want),
    .mode_q    (mode_q),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
  );

endmodule

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam int PWRUP = 20, CKE_LOW = 6, TRP = 2, TRFC = 4, TMRD = 1, NREF = 2;
  localparam int AW = 13, BW = 2, APB = 10;
  localparam int VW = 6 + BW + AW;
  localparam logic [VW-1:0] IDLE_V = {1'b0, 4'b1111, 1'b0, {BW{1'b0}}, {AW{1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_stable = 1'b0;
  logic ref_late = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;
  logic [VW-1:0] act;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(PWRUP), .CKE_LOW_CYC(CKE_LOW), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .TMRD_CYC(TMRD), .NUM_REF(NREF), .ADDR_W(AW), .BA_W(BW), .AP_BIT(APB)
  ) u0 (
    .clk(clk), .rst(rst), .clk_stable(clk_stable), .ref_late(ref_late),
    .mode_word(mode_word), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  assign act = {cke, cs_n, ras_n, cas_n, we_n, init_done, ba, addr};

  // Expected pin vector k edges after the start edge, from the requirement schedule
  function automatic void expect_at(input int k, input bit late, input logic [AW-1:0] mode,
                                    output logic [VW-1:0] vec, output string tag);
    logic [3:0] c;
    logic ck, dn, found;
    logic [AW-1:0] a;
    int t;
    c = 4'b0111; ck = 1'b1; dn = 1'b0; a = '0; t = PWRUP + 1; tag = "R6"; found = 1'b0;
    if (k <= CKE_LOW) begin
      c = 4'b1111; ck = 1'b0; tag = "R2";
    end else if (k <= PWRUP) begin
      tag = "R2";
    end else begin
      for (int i = 0; i < NREF + 2; i++) begin
        int kind;
        int gap;
        if (!found) begin
          if (i == 0)     kind = 0;
          else if (!late) kind = (i <= NREF) ? 1 : 2;
          else            kind = (i == 1) ? 2 : 1;
          gap = (kind == 0) ? TRP : ((kind == 1) ? TRFC : TMRD);
          if (k == t) begin
            found = 1'b1;
            case (kind)
              0:       begin c = 4'b0010; a = AW'(1) << APB; tag = "R3"; end
              1:       begin c = 4'b0001; tag = late ? "R5" : "R4"; end
              default: begin c = 4'b0000; a = mode; tag = "R7"; end
            endcase
          end else if (k < t + gap) begin
            found = 1'b1;
            tag = "R6";
          end
          t += gap;
        end
      end
      if (!found) begin dn = 1'b1; tag = "R8"; end
    end
    vec = {ck, c, dn, {BW{1'b0}}, a};
  endfunction

  task automatic chk(input string tag, input string what, input logic [VW-1:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(input bit late, input logic [AW-1:0] mode, input int stop_k, input bit perturb);
    logic [VW-1:0] e;
    string tag;
    int last;
    last = PWRUP + 1 + TRP + NREF * TRFC + TMRD + 5;
    clk_stable = 1'b1;
    ref_late = late;
    mode_word = mode;
    for (int k = 0; k <= last; k++) begin
      tick();
      expect_at(k, late, mode, e, tag);
      if (perturb) tag = {tag, "/R9"};
      chk(tag, $sformatf("cycle %0d late=%0b mode=%h", k, late, mode), e);
      if (perturb && k == 2) begin
        ref_late = ~late;
        mode_word = ~mode;
        clk_stable = 1'b0;
      end
      if (k == stop_k) break;
    end
  endtask

  task automatic restart(input string tag);
    rst = 1'b1;
    clk_stable = 1'b0;
    repeat (2) begin
      tick();
      chk(tag, "reset held", IDLE_V);
    end
    rst = 1'b0;
    repeat (3) begin
      tick();
      chk("R1", "idle awaiting clk_stable", IDLE_V);
    end
  endtask

  initial begin
    logic [AW-1:0] modes [4];
    modes = '{13'h0000, 13'h1FFF, 13'h0032, 13'h0A5A};
    repeat (3) begin
      tick();
      chk("R1", "in reset", IDLE_V);
    end
    rst = 1'b0;
    repeat (5) begin
      tick();
      chk("R1", "clk_stable low", IDLE_V);
    end
    for (int l = 0; l < 2; l++) begin
      for (int m = 0; m < 4; m++) begin
        run_seq(l[0], modes[m], -1, 1'b0);
        restart("R10");
      end
    end
    // R9: late input changes after start
    run_seq(1'b0, 13'h0123, -1, 1'b1);
    restart("R10");
    run_seq(1'b1, 13'h0456, -1, 1'b1);
    restart("R10");
    // R10: reset inside the CKE-low part and inside the command phase
    run_seq(1'b0, 13'h0155, 3, 1'b0);
    restart("R10");
    run_seq(1'b1, 13'h02AA, PWRUP + TRP + 2, 1'b0);
    restart("R10");
    run_seq(1'b1, 13'h00AA, -1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule